// File: doc/BRIEF.md
# Byte-Wide Register-Mapped SPI Master

This block is an SPI master controlled through a small byte-wide register port. The host sets the clock mode, the clock prescaler and the chip-select lines through registers. Writing one byte to the data register starts a transfer. The core shifts that byte out on the serial clock and data-out lines, most significant bit first. At the same time it samples the data-in line. When the transfer ends, the received byte is placed in a four-entry receive FIFO and a completion flag is raised.

The usual host sequence is as follows. Clear the memory-mode bit in the parameter register. Drive the wanted select low through the chip-select register. Then, for each byte, write the data register, poll the status register until its FIFO-empty bit reads 0, and read the data register to take the received byte. The host restores the parameter register when the message is finished. The timing register is storage only.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the registers read as follows: control 0x00, status 0x01 (only the FIFO-empty bit at bit 0 is set), data 0x00, extended control 0x00, parameter 0x01, chip-select 0xF0 and timing 0x00. After reset all select outputs are high and the serial clock is low.
- R2: The register offsets are control 0, status 1, data 2, extended control 3, parameter 4, chip-select 5 and timing 6. Control, extended control, parameter, chip-select and timing read back the full byte last written to them. In the status register, bits 5 to 1 always read 0 and bit 0 reads 1 exactly while the receive FIFO is empty.
- R3: A data-register write starts an 8-bit transfer when three conditions hold: control bit 6 (enable) is 1, parameter bit 0 is 0, and no transfer is running. The byte goes out most significant bit first. The received byte is pushed into the receive FIFO, and a read of the data register returns the oldest entry and removes it.
- R4: Control bit 3 selects the clock polarity and bit 2 selects the clock phase. While idle, the serial clock rests at the polarity level. With phase 0, data-in is sampled on each leading clock edge and data-out changes on trailing edges. With phase 1, data-out changes on leading edges and data-in is sampled on trailing edges.
- R5: The prescaler code has four bits: code bits [1:0] sit in control bits [1:0] and code bits [3:2] sit in extended-control bits [1:0]. Each half serial-clock period lasts ratio/2 system clocks, with these ratios: code 0 gives 2, 1 gives 4, 4 gives 8, 2 gives 16, 3 gives 32, and codes 5 to 11 give 2^(code+1). Codes 12 to 15 give 4096.
- R6: Status bit 7 (transfer complete) is set in the same cycle that the received byte enters the FIFO. Writing 1 to status bit 7 or bit 6 clears only that flag. Writing 0 leaves the flag unchanged.
- R7: A data-register write while a transfer is running sets status bit 6 (write collision). The written byte is discarded, and the running transfer completes unchanged.
- R8: Clearing the enable bit during a transfer stops it. The serial clock returns to the polarity level, no byte is pushed and the complete flag stays clear. A data write made while enable is 0 starts nothing.
- R9: While parameter bit 0 is 1, a data-register write starts no transfer and pushes nothing.
- R10: Chip-select bits 3 to 0 each enable software control of one select line, and bits 7 to 4 give the level for lines 0 to 3. A select output is low only when its enable bit is 1 and its level bit is 0. Otherwise it is high.
- R11: The receive FIFO holds 4 bytes. A byte that arrives while the FIFO is full is dropped. Reading the data register while the FIFO is empty returns 0x00 and leaves the FIFO empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Register access strobe, one cycle per access |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low select lines |

## Verification
The assertions watch several rules on every cycle:
- the idle clock level follows the polarity bit, and clearing enable ends a transfer;
- the FIFO never holds more than four entries, and it keeps its count when a byte arrives while it is full;
- a completion always leaves a byte in the FIFO;
- a data write during a transfer raises the collision flag, and a data write in memory mode starts nothing.

The serial framing can only be shown by the bench scenarios. A behavioural slave checks the bit order and the sampling edge in all four clock modes. The bench times the half period for each prescaler code, including the out-of-order codes and the saturated top range. It also checks the drop-newest rule on FIFO overflow and the decoding of the select nibbles.

// File: rtl/spi_bm_pkg.sv
`timescale 1ns/1ps
// Shared constants for the byte-wide SPI master: register offsets, bit
// positions and the prescaler code decode. Assumes 8-bit registers.
package spi_bm_pkg;
    localparam int REG_ADDR_W = 3;
    localparam int BYTE_W     = 8;

    localparam logic [REG_ADDR_W-1:0] OFS_CTRL   = 3'd0;
    localparam logic [REG_ADDR_W-1:0] OFS_STAT   = 3'd1;
    localparam logic [REG_ADDR_W-1:0] OFS_DATA   = 3'd2;
    localparam logic [REG_ADDR_W-1:0] OFS_EXT    = 3'd3;
    localparam logic [REG_ADDR_W-1:0] OFS_PARAM  = 3'd4;
    localparam logic [REG_ADDR_W-1:0] OFS_CSEL   = 3'd5;
    localparam logic [REG_ADDR_W-1:0] OFS_TIMING = 3'd6;

    localparam int CTRL_PHASE_BIT = 2;
    localparam int CTRL_POL_BIT   = 3;
    localparam int CTRL_EN_BIT    = 6;
    localparam int STAT_DONE_BIT  = 7;
    localparam int STAT_WCOL_BIT  = 6;
    localparam int STAT_EMPTY_BIT = 0;
    localparam int PARAM_MEM_BIT  = 0;

    localparam int DIV_CODE_W   = 4;
    localparam int MAX_LOG2_DIV = 12;

    // Configuration seen by the serial engine.
    typedef struct packed {
        logic                  enable;
        logic                  cpol;
        logic                  cpha;
        logic [DIV_CODE_W-1:0] div_code;
    } spi_cfg_t;

    // Maps a prescaler code to log2 of its divide ratio (interleaved order).
    function automatic logic [3:0] div_code_log2(input logic [DIV_CODE_W-1:0] code);
        logic [3:0] l2;
        case (code)
            4'd0:    l2 = 4'd1;
            4'd1:    l2 = 4'd2;
            4'd4:    l2 = 4'd3;
            4'd2:    l2 = 4'd4;
            4'd3:    l2 = 4'd5;
            default: l2 = (code >= 4'd12) ? 4'(MAX_LOG2_DIV) : code + 4'd1;
        endcase
        return l2;
    endfunction
endpackage

// File: rtl/spi_bm_clkdiv.sv
`timescale 1ns/1ps
// Half-period tick generator. While run is high it pulses tick once every
// ratio/2 system clocks; the count restarts whenever run is low.
// Assumes the prescaler code is stable during a transfer.
module spi_bm_clkdiv
    import spi_bm_pkg::*;
#(
    parameter int LOG2_MAX = MAX_LOG2_DIV
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic [DIV_CODE_W-1:0] div_code,
    output logic                  tick
);
    localparam int CNT_W = LOG2_MAX;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_m1;
    logic [3:0]       l2;

    // Terminal count for one half period.
    always_comb begin
        l2      = div_code_log2(div_code);
        half_m1 = (CNT_W'(1) << (l2 - 4'd1)) - CNT_W'(1);
        tick    = run && (cnt_q == half_m1);
    end

    // Half-period counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (tick)      cnt_q <= '0;
        else                cnt_q <= cnt_q + CNT_W'(1);
    end

    p_tick_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run && !tick |=> cnt_q != '0 || !run);
endmodule

// File: rtl/spi_bm_rxfifo.sv
`timescale 1ns/1ps
// Receive FIFO. A push while full drops the incoming byte; a pop while
// empty is ignored. dout shows the oldest entry, or zero when empty.
module spi_bm_rxfifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             push_ok, pop_ok;

    // Accept conditions and output view.
    always_comb begin
        empty   = (count_q == '0);
        full    = (count_q == CNT_W'(DEPTH));
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        dout    = empty ? '0 : mem_q[rd_ptr_q];
    end

    // Pointer wrap helper.
    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_ok) wr_ptr_q <= nxt(wr_ptr_q);
            if (pop_ok)  rd_ptr_q <= nxt(rd_ptr_q);
            if (push_ok && !pop_ok)      count_q <= count_q + CNT_W'(1);
            else if (pop_ok && !push_ok) count_q <= count_q - CNT_W'(1);
        end
    end

    // Storage.
    always_ff @(posedge clk) begin
        if (push_ok) mem_q[wr_ptr_q] <= din;
    end

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));
    p_full_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        push && full && !pop |=> count_q == $past(count_q));
endmodule

// File: rtl/spi_bm_shifter.sv
`timescale 1ns/1ps
// Serial engine: runs 2*BITS clock edges per transfer, MSB first, in any of
// the four polarity/phase modes. done pulses on the final edge together with
// the completed receive byte. Clearing enable aborts without a result.
module spi_bm_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [BITS-1:0] tx_byte,
    input  logic            cpol,
    input  logic            cpha,
    input  logic            enable,
    input  logic            tick,
    input  logic            miso,
    output logic            busy,
    output logic            sclk,
    output logic            mosi,
    output logic            done,
    output logic [BITS-1:0] rx_byte
);
    localparam int EDGES  = 2 * BITS;
    localparam int EDGE_W = $clog2(EDGES);

    logic [EDGE_W-1:0] edge_q;
    logic [BITS-1:0]   txs_q, rxs_q;
    logic              sclk_q, mosi_q, busy_q;
    logic              last_edge, leading, do_sample, do_launch;

    // Edge classification for the current tick.
    always_comb begin
        last_edge = (edge_q == EDGE_W'(EDGES - 1));
        leading   = !edge_q[0];
        do_sample = (leading != cpha);
        do_launch = cpha ? leading : (!leading && !last_edge);
        done      = busy_q && enable && tick && last_edge;
        rx_byte   = cpha ? {rxs_q[BITS-2:0], miso} : rxs_q;
        busy      = busy_q;
        sclk      = sclk_q;
        mosi      = mosi_q;
    end

    // Transfer sequencing, clock toggling and data shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            edge_q <= '0;
            sclk_q <= 1'b0;
            mosi_q <= 1'b0;
            txs_q  <= '0;
            rxs_q  <= '0;
        end else if (!busy_q) begin
            sclk_q <= cpol;
            edge_q <= '0;
            if (start) begin
                busy_q <= 1'b1;
                if (!cpha) begin
                    mosi_q <= tx_byte[BITS-1];
                    txs_q  <= {tx_byte[BITS-2:0], 1'b0};
                end else begin
                    txs_q  <= tx_byte;
                end
            end
        end else if (!enable) begin
            busy_q <= 1'b0;
            sclk_q <= cpol;
        end else if (tick) begin
            sclk_q <= ~sclk_q;
            edge_q <= edge_q + EDGE_W'(1);
            if (do_sample) rxs_q <= {rxs_q[BITS-2:0], miso};
            if (do_launch) begin
                mosi_q <= txs_q[BITS-1];
                txs_q  <= {txs_q[BITS-2:0], 1'b0};
            end
            if (last_edge) busy_q <= 1'b0;
        end
    end

    p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!busy_q) && !busy_q |-> sclk_q == $past(cpol));
    p_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !enable |=> !busy_q);
endmodule

// File: rtl/spi_bm_regs.sv
`timescale 1ns/1ps
// Host register file: decodes byte accesses, holds configuration, keeps the
// sticky status flags (write 1 to clear) and issues start and FIFO-pop.
// Assumes one access per host_valid cycle.
module spi_bm_regs
    import spi_bm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_valid,
    input  logic                  host_write,
    input  logic [REG_ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0]     host_wdata,
    output logic [BYTE_W-1:0]     host_rdata,
    input  logic                  busy,
    input  logic                  xfer_done,
    input  logic                  rx_empty,
    input  logic [BYTE_W-1:0]     rx_head,
    output spi_cfg_t              cfg,
    output logic                  start,
    output logic [BYTE_W-1:0]     start_byte,
    output logic                  pop,
    output logic [BYTE_W-1:0]     csel
);
    logic [BYTE_W-1:0] ctrl_q, ext_q, param_q, csel_q, timing_q;
    logic              done_q, wcol_q;
    logic              wr, data_wr, stat_wr;

    // Access decode and derived controls.
    always_comb begin
        wr           = host_valid && host_write;
        data_wr      = wr && (host_addr == OFS_DATA);
        stat_wr      = wr && (host_addr == OFS_STAT);
        cfg.enable   = ctrl_q[CTRL_EN_BIT];
        cfg.cpol     = ctrl_q[CTRL_POL_BIT];
        cfg.cpha     = ctrl_q[CTRL_PHASE_BIT];
        cfg.div_code = {ext_q[1:0], ctrl_q[1:0]};
        start        = data_wr && !busy && cfg.enable && !param_q[PARAM_MEM_BIT];
        start_byte   = host_wdata;
        pop          = host_valid && !host_write && (host_addr == OFS_DATA) && !rx_empty;
        csel         = csel_q;
    end

    // Read multiplexer.
    always_comb begin
        host_rdata = '0;
        case (host_addr)
            OFS_CTRL:   host_rdata = ctrl_q;
            OFS_STAT: begin
                host_rdata[STAT_DONE_BIT]  = done_q;
                host_rdata[STAT_WCOL_BIT]  = wcol_q;
                host_rdata[STAT_EMPTY_BIT] = rx_empty;
            end
            OFS_DATA:   host_rdata = rx_head;
            OFS_EXT:    host_rdata = ext_q;
            OFS_PARAM:  host_rdata = param_q;
            OFS_CSEL:   host_rdata = csel_q;
            OFS_TIMING: host_rdata = timing_q;
            default:    host_rdata = '0;
        endcase
    end

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            ext_q    <= '0;
            param_q  <= 8'h01;
            csel_q   <= 8'hF0;
            timing_q <= '0;
        end else if (wr) begin
            case (host_addr)
                OFS_CTRL:   ctrl_q   <= host_wdata;
                OFS_EXT:    ext_q    <= host_wdata;
                OFS_PARAM:  param_q  <= host_wdata;
                OFS_CSEL:   csel_q   <= host_wdata;
                OFS_TIMING: timing_q <= host_wdata;
                default: ;
            endcase
        end
    end

    // Sticky flags: set has priority over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            wcol_q <= 1'b0;
        end else begin
            if (xfer_done)                                  done_q <= 1'b1;
            else if (stat_wr && host_wdata[STAT_DONE_BIT])  done_q <= 1'b0;
            if (data_wr && busy)                            wcol_q <= 1'b1;
            else if (stat_wr && host_wdata[STAT_WCOL_BIT])  wcol_q <= 1'b0;
        end
    end

    p_wcol_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && busy |=> wcol_q);
    p_mem_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && param_q[PARAM_MEM_BIT] && !busy |=> !busy);
endmodule

// File: rtl/spi_byte_master.sv
`timescale 1ns/1ps
// Top of the byte-wide register-mapped SPI master: register file, prescaler,
// serial engine, receive FIFO and software chip-select outputs.
// Assumes NUM_CS <= 4 (enable nibble low, level nibble high).
module spi_byte_master
    import spi_bm_pkg::*;
#(
    parameter int NUM_CS   = 4,
    parameter int RX_DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_valid,
    input  logic                  host_write,
    input  logic [REG_ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0]     host_wdata,
    output logic [BYTE_W-1:0]     host_rdata,
    output logic                  spi_sclk,
    output logic                  spi_mosi,
    input  logic                  spi_miso,
    output logic [NUM_CS-1:0]     spi_cs_n
);
    localparam int LEVEL_OFS = BYTE_W / 2;

    spi_cfg_t          cfg;
    logic              start, pop, busy, done, tick, rx_empty, rx_full;
    logic [BYTE_W-1:0] start_byte, rx_byte, rx_head, csel;

    spi_bm_regs u_regs (
        .clk, .rst_n, .host_valid, .host_write, .host_addr, .host_wdata,
        .host_rdata, .busy, .xfer_done(done), .rx_empty, .rx_head,
        .cfg, .start, .start_byte, .pop, .csel
    );

    spi_bm_clkdiv #(.LOG2_MAX(MAX_LOG2_DIV)) u_div (
        .clk, .rst_n, .run(busy && cfg.enable), .div_code(cfg.div_code), .tick
    );

    spi_bm_shifter #(.BITS(BYTE_W)) u_shift (
        .clk, .rst_n, .start, .tx_byte(start_byte), .cpol(cfg.cpol),
        .cpha(cfg.cpha), .enable(cfg.enable), .tick, .miso(spi_miso),
        .busy, .sclk(spi_sclk), .mosi(spi_mosi), .done, .rx_byte
    );

    spi_bm_rxfifo #(.DEPTH(RX_DEPTH), .WIDTH(BYTE_W)) u_fifo (
        .clk, .rst_n, .push(done), .din(rx_byte), .pop,
        .dout(rx_head), .empty(rx_empty), .full(rx_full)
    );

    // One select output per line from its enable and level bits.
    for (genvar n = 0; n < NUM_CS; n++) begin : g_cs
        assign spi_cs_n[n] = csel[n] ? csel[n + LEVEL_OFS] : 1'b1;
    end

    p_done_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !rx_empty);
    p_full_known_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> !rx_empty);
endmodule

// File: tb/sim_spi_byte_master.sv
`timescale 1ns/1ps
module sim_spi_byte_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_valid = 1'b0, host_write = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       spi_sclk, spi_mosi, spi_miso;
    logic [3:0] spi_cs_n;

    int checks = 0, failures = 0;

    // Behavioural slave state.
    logic       sl_armed = 1'b0, sl_cpol = 1'b0, sl_cpha = 1'b0;
    logic [8:0] s9 = '0;
    logic [7:0] cap = '0;

    always #5 clk = ~clk;

    spi_byte_master u0 (
        .clk, .rst_n, .host_valid, .host_write, .host_addr, .host_wdata,
        .host_rdata, .spi_sclk, .spi_mosi, .spi_miso, .spi_cs_n
    );

    assign spi_miso = s9[8];

    always @(spi_sclk) begin
        if (sl_armed) begin
            if (spi_sclk != sl_cpol) begin
                if (sl_cpha) s9 <= {s9[7:0], 1'b0};
                else         cap <= {cap[6:0], spi_mosi};
            end else begin
                if (sl_cpha) cap <= {cap[6:0], spi_mosi};
                else         s9 <= {s9[7:0], 1'b0};
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_valid = 1'b0; host_write = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b0; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_valid = 1'b0;
    endtask

    task automatic setup_mode(input logic pol, input logic pha, input logic [3:0] code);
        wr(3'd0, {1'b0, 1'b1, 2'b00, pol, pha, code[1:0]});
        wr(3'd3, {6'd0, code[3:2]});
        wr(3'd4, 8'h00);
        sl_cpol = pol; sl_cpha = pha;
        repeat (2) @(negedge clk);
    endtask

    task automatic launch(input logic [7:0] tx, input logic [7:0] sl);
        s9 = sl_cpha ? {1'b0, sl} : {sl, 1'b0};
        cap = '0; sl_armed = 1'b1;
        wr(3'd2, tx);
    endtask

    // Polls until the FIFO is non-empty; checks done flag in the same read.
    task automatic wait_done(input string tag);
        logic [7:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd1, s);
            if (!s[0]) break;
        end
        chk({tag, " done with byte"}, s[7], 1);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(3'd0, v); chk("R1 ctrl", v, 8'h00);
        rd(3'd1, v); chk("R1 status", v, 8'h01);
        rd(3'd2, v); chk("R1 data", v, 8'h00);
        rd(3'd3, v); chk("R1 ext", v, 8'h00);
        rd(3'd4, v); chk("R1 param", v, 8'h01);
        rd(3'd5, v); chk("R1 csel", v, 8'hF0);
        rd(3'd6, v); chk("R1 timing", v, 8'h00);
        chk("R1 cs_n", spi_cs_n, 4'hF);
        chk("R1 sclk", spi_sclk, 0);
    endtask

    task automatic t_readback;
        logic [7:0] v;
        wr(3'd0, 8'h8B); rd(3'd0, v); chk("R2 ctrl", v, 8'h8B);
        wr(3'd3, 8'hA5); rd(3'd3, v); chk("R2 ext", v, 8'hA5);
        wr(3'd4, 8'h5A); rd(3'd4, v); chk("R2 param", v, 8'h5A);
        wr(3'd6, 8'h3C); rd(3'd6, v); chk("R2 timing", v, 8'h3C);
        wr(3'd5, 8'h96); rd(3'd5, v); chk("R2 csel", v, 8'h96);
        wr(3'd1, 8'h3E); rd(3'd1, v); chk("R2 status fixed bits", v, 8'h01);
        wr(3'd0, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h01); wr(3'd5, 8'hF0);
    endtask

    task automatic t_modes;
        logic [7:0] v;
        logic [7:0] txs [4] = '{8'hA5, 8'h3C, 8'h81, 8'h6E};
        logic [7:0] sls [4] = '{8'h5A, 8'hC3, 8'h17, 8'hF0};
        for (int m = 0; m < 4; m++) begin
            setup_mode(m[1], m[0], 4'(m % 2));
            chk("R4 idle level", spi_sclk, int'(m[1]));
            launch(txs[m], sls[m]);
            wait_done("R3");
            rd(3'd2, v); chk("R3 R4 rx byte", v, sls[m]);
            chk("R3 R4 tx order", cap, txs[m]);
            chk("R4 rest level", spi_sclk, int'(m[1]));
            rd(3'd1, v); chk("R3 empty after pop", v[0], 1);
            sl_armed = 1'b0;
            wr(3'd1, 8'hC0);
        end
    endtask

    task automatic t_fifo;
        logic [7:0] v;
        setup_mode(1'b0, 1'b0, 4'd0);
        for (int k = 0; k < 5; k++) begin
            launch(8'h00, 8'(8'h11 * (k + 1)));
            repeat (30) @(negedge clk);
        end
        for (int k = 0; k < 4; k++) begin
            rd(3'd2, v); chk("R11 fifo order", v, 8'h11 * (k + 1));
        end
        rd(3'd1, v); chk("R11 fifth dropped", v[0], 1);
        rd(3'd2, v); chk("R11 empty read", v, 8'h00);
        rd(3'd1, v); chk("R11 still empty", v[0], 1);
        sl_armed = 1'b0;
        wr(3'd1, 8'hC0);
    endtask

    task automatic t_wcol;
        logic [7:0] v;
        setup_mode(1'b0, 1'b0, 4'd3);
        launch(8'h12, 8'h9D);
        wr(3'd2, 8'hFF);
        rd(3'd1, v); chk("R7 wcol set", v, 8'h41);
        wait_done("R7");
        chk("R7 tx unchanged", cap, 8'h12);
        rd(3'd2, v); chk("R7 rx byte", v, 8'h9D);
        rd(3'd1, v); chk("R7 one byte only", v, 8'hC1);
        wr(3'd1, 8'h40); rd(3'd1, v); chk("R6 clear wcol only", v, 8'h81);
        wr(3'd1, 8'h00); rd(3'd1, v); chk("R6 write 0 keeps", v, 8'h81);
        wr(3'd1, 8'h80); rd(3'd1, v); chk("R6 clear done", v, 8'h01);
        sl_armed = 1'b0;
    endtask

    task automatic t_div(input logic [3:0] code, input int half);
        logic [7:0] v;
        time t1, t2;
        setup_mode(1'b0, 1'b0, code);
        wr(3'd2, 8'hA5);
        @(spi_sclk); t1 = $time;
        @(spi_sclk); t2 = $time;
        chk($sformatf("R5 half period code %0d", code), int'((t2 - t1) / 10), half);
        wr(3'd0, 8'h00);
        repeat (3) @(negedge clk);
        chk("R8 abort sclk", spi_sclk, 0);
        rd(3'd1, v); chk("R8 abort no byte", v, 8'h01);
    endtask

    task automatic t_block;
        logic [7:0] v;
        setup_mode(1'b1, 1'b0, 4'd0);
        wr(3'd4, 8'h01);
        wr(3'd2, 8'h55);
        repeat (40) @(negedge clk);
        rd(3'd1, v); chk("R9 mem mode blocks", v, 8'h01);
        chk("R9 sclk idle", spi_sclk, 1);
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h08);
        wr(3'd2, 8'h55);
        repeat (40) @(negedge clk);
        rd(3'd1, v); chk("R8 disabled write ignored", v, 8'h01);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_cs;
        wr(3'd5, 8'hE1); chk("R10 line0 low", spi_cs_n, 4'b1110);
        wr(3'd5, 8'h0F); chk("R10 all low", spi_cs_n, 4'b0000);
        wr(3'd5, 8'hFF); chk("R10 all released", spi_cs_n, 4'b1111);
        wr(3'd5, 8'hA5); chk("R10 mixed", spi_cs_n, 4'b1010);
        wr(3'd5, 8'h00); chk("R10 no enables", spi_cs_n, 4'b1111);
    endtask

    initial begin
        #3_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_modes();
        t_fifo();
        t_wcol();
        t_div(4'd0, 1);
        t_div(4'd1, 2);
        t_div(4'd4, 4);
        t_div(4'd2, 8);
        t_div(4'd3, 16);
        t_div(4'd5, 32);
        t_div(4'd11, 2048);
        t_div(4'd14, 2048);
        t_block();
        t_cs();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule